// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Generator

This block generates the active-low strobe waveforms for one chip select of an asynchronous static memory port. A request accepted while the block is ready starts one access. A single access counter runs from cycle 0. The chip-select strobe and the data strobe (the read strobe on a read, the write strobe on a write) each have their own programmed setup and pulse lengths. Each strobe is low only inside its own window. The whole access lasts a programmed total length, which is stretched when a strobe window would run past it.

The timing fields use a compressed encoding. A setup field is 6 bits, a pulse field is 7 bits and a total-length field is 9 bits. In each field a high bit or bit pair carries a heavy weight, so short and very long accesses fit in few bits. A per-direction control bit picks which strobe marks the data point, and a sample pulse is raised when that strobe returns high. An external wait input can freeze the access or stretch the end of a pulse. After a read, a programmable float gap holds off the next access so the memory can release the data bus.

Top module: `sram_cs_timing`

## Requirements
- R1: After reset, cs_n_o, rd_n_o and wr_n_o are high, done_o and sample_o are low and ready_o is high.
- R2: A request is accepted at a rising edge where req_i and ready_o are both high. The configuration inputs and we_i are captured at that edge. The next cycle is access cycle 0, and ready_o is low from then on until the access ends.
- R3: A setup field of 6 bits decodes to 128·bit5 + bits[4:0] cycles. A strobe goes low first in the access cycle whose index equals its decoded setup.
- R4: A pulse field of 7 bits decodes to 128·bit6 + bits[5:0] cycles. This is the number of cycles the strobe stays low when no wait is applied. A pulse of 0 keeps the strobe high for the whole access.
- R5: A total field of 9 bits decodes to 256·bits[8:7] + bits[6:0] cycles. The access length T is the largest of that value, chip-select setup+pulse, data-strobe setup+pulse and 1. done_o is high for exactly one cycle, in cycle index T.
- R6: we_i=1 makes an access a write: wr_n_o follows the data-strobe window, the write field set is used, and rd_n_o stays high. we_i=0 does the opposite. rd_n_o and wr_n_o are never low together.
- R7: Every strobe is high while ready_o is high and in the done cycle, even when the total field is shorter than a strobe's setup+pulse.
- R8: The control bit for the access direction selects which strobe controls the data point: 0 selects the chip-select strobe, 1 the data strobe. sample_o pulses for one cycle, in the cycle index equal to the controlling strobe's setup+pulse, with no wait applied. There is no pulse when that strobe's pulse is 0.
- R9: wait_mode_i is a 2-bit code captured at start: 0 and 1 disable waiting and ext_wait_ni has no effect, 2 is freeze and 3 is ready.
- R10: In freeze mode, each access cycle with ext_wait_ni low holds the counter. The strobes keep their levels, and the access grows by one cycle for each such cycle.
- R11: In ready mode, an access cycle that is the last low cycle of any strobe repeats while ext_wait_ni is low. Low wait in other cycles has no effect.
- R12: After a read with float value F (4 bits), ready_o stays low for F cycles starting at the done cycle. Requests in those cycles are ignored. After a write, ready_o is high in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| cs_setup_rd_i | input | 6 | Chip-select setup, read |
| cs_setup_wr_i | input | 6 | Chip-select setup, write |
| strb_setup_rd_i | input | 6 | Read strobe setup |
| strb_setup_wr_i | input | 6 | Write strobe setup |
| cs_pulse_rd_i | input | 7 | Chip-select pulse, read |
| cs_pulse_wr_i | input | 7 | Chip-select pulse, write |
| strb_pulse_rd_i | input | 7 | Read strobe pulse |
| strb_pulse_wr_i | input | 7 | Write strobe pulse |
| cycle_rd_i | input | 9 | Total read length |
| cycle_wr_i | input | 9 | Total write length |
| rd_ctl_strb_i | input | 1 | Read controlled by strobe (1) or chip select (0) |
| wr_ctl_strb_i | input | 1 | Write controlled by strobe (1) or chip select (0) |
| wait_mode_i | input | 2 | Wait handling code |
| float_cycles_i | input | 4 | Bus float gap after a read |
| ext_wait_ni | input | 1 | External wait, active low |
| ready_o | output | 1 | A request can be accepted |
| done_o | output | 1 | One-cycle end-of-access pulse |
| sample_o | output | 1 | Controlling strobe has just risen |
| cs_n_o | output | 1 | Chip-select strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
Cycles are counted from the accepting edge, and the cycle after that edge is index 0. The strobes are decoded from the registered counter, so a strobe shows its level within the counted cycle itself. done_o and sample_o are registered, so each one appears in the cycle after the counted cycle that causes it (index T and index setup+pulse). The bench samples every output at the falling clock edge and records each event against that index. It applies wait changes at the same falling edge, so each change acts on the edge that closes the current cycle. Each expected index comes from the decode formulas above.

// File: rtl/sram_tmg_pkg.sv
package sram_tmg_pkg;
  localparam int SETUP_W = 6;
  localparam int PULSE_W = 7;
  localparam int CYCLE_W = 9;
  localparam int FLT_W   = 4;
  localparam int MODE_W  = 2;
  localparam int LEN_W   = 8;   // decoded setup/pulse
  localparam int CNT_W   = 10;  // decoded total length
  localparam int N_WIN   = 2;   // 0: chip select, 1: data strobe

  typedef enum logic [MODE_W-1:0] {
    WAIT_OFF    = 2'd0,
    WAIT_OFF_B  = 2'd1,
    WAIT_FREEZE = 2'd2,
    WAIT_READY  = 2'd3
  } wait_mode_e;

  typedef struct packed {
    logic [LEN_W-1:0] cs_setup;
    logic [LEN_W-1:0] cs_pulse;
    logic [LEN_W-1:0] st_setup;
    logic [LEN_W-1:0] st_pulse;
    logic [CNT_W-1:0] total;
    logic             ctl_strobe;
  } timing_t;

  function automatic logic [LEN_W-1:0] dec_setup(input logic [SETUP_W-1:0] f);
    logic [LEN_W-1:0] r;
    r = '0;
    r[LEN_W-1]     = f[SETUP_W-1];
    r[SETUP_W-2:0] = f[SETUP_W-2:0];
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] dec_pulse(input logic [PULSE_W-1:0] f);
    logic [LEN_W-1:0] r;
    r = '0;
    r[LEN_W-1]     = f[PULSE_W-1];
    r[PULSE_W-2:0] = f[PULSE_W-2:0];
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] dec_cycle(input logic [CYCLE_W-1:0] f);
    logic [CNT_W-1:0] r;
    r = '0;
    r[CNT_W-1:CNT_W-2] = f[CYCLE_W-1:CYCLE_W-2];
    r[CYCLE_W-3:0]     = f[CYCLE_W-3:0];
    return r;
  endfunction
endpackage

// File: rtl/tmg_decode.sv
module tmg_decode
  import sram_tmg_pkg::*;
(
  input  logic               we_i,
  input  logic [SETUP_W-1:0] cs_setup_rd_i,
  input  logic [SETUP_W-1:0] cs_setup_wr_i,
  input  logic [SETUP_W-1:0] strb_setup_rd_i,
  input  logic [SETUP_W-1:0] strb_setup_wr_i,
  input  logic [PULSE_W-1:0] cs_pulse_rd_i,
  input  logic [PULSE_W-1:0] cs_pulse_wr_i,
  input  logic [PULSE_W-1:0] strb_pulse_rd_i,
  input  logic [PULSE_W-1:0] strb_pulse_wr_i,
  input  logic [CYCLE_W-1:0] cycle_rd_i,
  input  logic [CYCLE_W-1:0] cycle_wr_i,
  input  logic               rd_ctl_strb_i,
  input  logic               wr_ctl_strb_i,
  output timing_t            t_o
);
  logic [CNT_W-1:0] cyc, cs_end, st_end, len;

  always_comb begin
    t_o.cs_setup   = dec_setup(we_i ? cs_setup_wr_i   : cs_setup_rd_i);
    t_o.st_setup   = dec_setup(we_i ? strb_setup_wr_i : strb_setup_rd_i);
    t_o.cs_pulse   = dec_pulse(we_i ? cs_pulse_wr_i   : cs_pulse_rd_i);
    t_o.st_pulse   = dec_pulse(we_i ? strb_pulse_wr_i : strb_pulse_rd_i);
    t_o.ctl_strobe = we_i ? wr_ctl_strb_i : rd_ctl_strb_i;
    cyc    = dec_cycle(we_i ? cycle_wr_i : cycle_rd_i);
    cs_end = CNT_W'(t_o.cs_setup) + CNT_W'(t_o.cs_pulse);
    st_end = CNT_W'(t_o.st_setup) + CNT_W'(t_o.st_pulse);
    // stretch so every strobe window fits inside the access
    len = cyc;
    if (cs_end > len) len = cs_end;
    if (st_end > len) len = st_end;
    if (len == '0) len = CNT_W'(1);
    t_o.total = len;
  end
endmodule

// File: rtl/tmg_window.sv
module tmg_window #(
  parameter int CNT_W = 10,
  parameter int LEN_W = 8
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] setup_i,
  input  logic [LEN_W-1:0] pulse_i,
  output logic             low_o,
  output logic             last_o
);
  logic [CNT_W-1:0] beg_c, end_c;

  always_comb begin
    beg_c  = CNT_W'(setup_i);
    end_c  = beg_c + CNT_W'(pulse_i);
    low_o  = active_i && (cnt_i >= beg_c) && (cnt_i < end_c);
    last_o = active_i && (pulse_i != '0) && (cnt_i == end_c - CNT_W'(1));
  end
endmodule

// File: rtl/tmg_gap.sv
module tmg_gap #(
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [FLT_W-1:0] val_i,
  input  logic             active_i,
  output logic             busy_o
);
  logic [FLT_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        gap_q <= '0;
    else if (load_i)                    gap_q <= val_i;
    else if (!active_i && gap_q != '0)  gap_q <= gap_q - FLT_W'(1);
  end

  assign busy_o = (gap_q != '0);
endmodule

// File: rtl/sram_cs_timing.sv
module sram_cs_timing
  import sram_tmg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [SETUP_W-1:0] cs_setup_rd_i,
  input  logic [SETUP_W-1:0] cs_setup_wr_i,
  input  logic [SETUP_W-1:0] strb_setup_rd_i,
  input  logic [SETUP_W-1:0] strb_setup_wr_i,
  input  logic [PULSE_W-1:0] cs_pulse_rd_i,
  input  logic [PULSE_W-1:0] cs_pulse_wr_i,
  input  logic [PULSE_W-1:0] strb_pulse_rd_i,
  input  logic [PULSE_W-1:0] strb_pulse_wr_i,
  input  logic [CYCLE_W-1:0] cycle_rd_i,
  input  logic [CYCLE_W-1:0] cycle_wr_i,
  input  logic               rd_ctl_strb_i,
  input  logic               wr_ctl_strb_i,
  input  logic [MODE_W-1:0]  wait_mode_i,
  input  logic [FLT_W-1:0]   float_cycles_i,
  input  logic               ext_wait_ni,
  output logic               ready_o,
  output logic               done_o,
  output logic               sample_o,
  output logic               cs_n_o,
  output logic               rd_n_o,
  output logic               wr_n_o
);
  timing_t          dec_t, cfg_q;
  logic             active_q, wr_q, done_q, sample_q;
  logic [CNT_W-1:0] cnt_q;
  wait_mode_e       mode_q;
  logic [FLT_W-1:0] flt_q;
  logic             gap_busy, start, hold, last_cyc, ctl_last;
  logic [N_WIN-1:0] win_low, win_last;
  logic [LEN_W-1:0] win_setup [N_WIN];
  logic [LEN_W-1:0] win_pulse [N_WIN];

  tmg_decode u_dec (
    .we_i            (we_i),
    .cs_setup_rd_i   (cs_setup_rd_i),
    .cs_setup_wr_i   (cs_setup_wr_i),
    .strb_setup_rd_i (strb_setup_rd_i),
    .strb_setup_wr_i (strb_setup_wr_i),
    .cs_pulse_rd_i   (cs_pulse_rd_i),
    .cs_pulse_wr_i   (cs_pulse_wr_i),
    .strb_pulse_rd_i (strb_pulse_rd_i),
    .strb_pulse_wr_i (strb_pulse_wr_i),
    .cycle_rd_i      (cycle_rd_i),
    .cycle_wr_i      (cycle_wr_i),
    .rd_ctl_strb_i   (rd_ctl_strb_i),
    .wr_ctl_strb_i   (wr_ctl_strb_i),
    .t_o             (dec_t)
  );

  assign win_setup[0] = cfg_q.cs_setup;
  assign win_pulse[0] = cfg_q.cs_pulse;
  assign win_setup[1] = cfg_q.st_setup;
  assign win_pulse[1] = cfg_q.st_pulse;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    tmg_window #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_win (
      .active_i (active_q),
      .cnt_i    (cnt_q),
      .setup_i  (win_setup[g]),
      .pulse_i  (win_pulse[g]),
      .low_o    (win_low[g]),
      .last_o   (win_last[g])
    );
  end

  tmg_gap #(.FLT_W(FLT_W)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (last_cyc && !wr_q),
    .val_i    (flt_q),
    .active_i (active_q),
    .busy_o   (gap_busy)
  );

  assign ready_o  = !active_q && !gap_busy;
  assign start    = req_i && ready_o;
  assign hold     = active_q && !ext_wait_ni &&
                    ((mode_q == WAIT_FREEZE) || ((mode_q == WAIT_READY) && (|win_last)));
  assign last_cyc = active_q && !hold && (cnt_q == cfg_q.total - CNT_W'(1));
  assign ctl_last = cfg_q.ctl_strobe ? win_last[1] : win_last[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      cfg_q    <= '0;
      wr_q     <= 1'b0;
      mode_q   <= WAIT_OFF;
      flt_q    <= '0;
      done_q   <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      done_q   <= last_cyc;
      sample_q <= active_q && !hold && ctl_last;
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        cfg_q    <= dec_t;
        wr_q     <= we_i;
        mode_q   <= wait_mode_e'(wait_mode_i);
        flt_q    <= float_cycles_i;
      end else if (active_q && !hold) begin
        if (last_cyc) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q    <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign done_o   = done_q;
  assign sample_o = sample_q;
  assign cs_n_o   = !win_low[0];
  assign rd_n_o   = !(win_low[1] && !wr_q);
  assign wr_n_o   = !(win_low[1] && wr_q);
endmodule

// File: rtl/tmg_checker.sv
module tmg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       ext_wait_ni,
  input logic       ready_o,
  input logic       done_o,
  input logic       sample_o,
  input logic       cs_n_o,
  input logic       rd_n_o,
  input logic       wr_n_o,
  input logic       active_i,
  input logic [1:0] mode_i
);
  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_rw_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (rd_n_o || wr_n_o));

  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && rd_n_o && wr_n_o));

  assert_ready_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cs_n_o && rd_n_o && wr_n_o));

  assert_sample_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  assert_freeze_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && mode_i == 2'd2 && !ext_wait_ni)
      |=> ($stable({cs_n_o, rd_n_o, wr_n_o}) && !done_o));
endmodule

bind sram_cs_timing tmg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ext_wait_ni (ext_wait_ni),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .sample_o    (sample_o),
  .cs_n_o      (cs_n_o),
  .rd_n_o      (rd_n_o),
  .wr_n_o      (wr_n_o),
  .active_i    (active_q),
  .mode_i      (mode_q)
);

// File: tb/tb_sram_cs_timing.sv
module tb_sram_cs_timing;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] cs_set_rd = '0, cs_set_wr = '0, st_set_rd = '0, st_set_wr = '0;
  logic [6:0] cs_pul_rd = '0, cs_pul_wr = '0, st_pul_rd = '0, st_pul_wr = '0;
  logic [8:0] cyc_rd = '0, cyc_wr = '0;
  logic rd_ctl = 1'b0, wr_ctl = 1'b0;
  logic [1:0] wmode = '0;
  logic [3:0] flt = '0;
  logic wait_n = 1'b1;
  logic ready, done, sample, cs_n, rd_n, wr_n;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sram_cs_timing dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .cs_setup_rd_i(cs_set_rd), .cs_setup_wr_i(cs_set_wr),
    .strb_setup_rd_i(st_set_rd), .strb_setup_wr_i(st_set_wr),
    .cs_pulse_rd_i(cs_pul_rd), .cs_pulse_wr_i(cs_pul_wr),
    .strb_pulse_rd_i(st_pul_rd), .strb_pulse_wr_i(st_pul_wr),
    .cycle_rd_i(cyc_rd), .cycle_wr_i(cyc_wr),
    .rd_ctl_strb_i(rd_ctl), .wr_ctl_strb_i(wr_ctl),
    .wait_mode_i(wmode), .float_cycles_i(flt), .ext_wait_ni(wait_n),
    .ready_o(ready), .done_o(done), .sample_o(sample),
    .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  css;
    logic [5:0]  sts;
    logic [6:0]  csp;
    logic [6:0]  stp;
    logic [8:0]  cyc;
    logic        ctl;
    logic signed [15:0] e_cs_s, e_cs_l, e_st_s, e_st_l, e_tot, e_smp;
  } vec_t;

  // expected: cs start/len, strobe start/len, done index, sample index (-1 = none)
  localparam vec_t VECS [4] = '{
    '{1'b1, 6'd1, 6'd2, 7'd6, 7'd3, 9'd8, 1'b1,
      16'sd1, 16'sd6, 16'sd2, 16'sd3, 16'sd8, 16'sd5},
    '{1'b0, 6'd0, 6'd1, 7'd4, 7'd2, 9'd3, 1'b0,
      16'sd0, 16'sd4, 16'sd1, 16'sd2, 16'sd4, 16'sd4},
    '{1'b0, 6'd2, 6'b100000, 7'd5, 7'b1000000, 9'b100000011, 1'b1,
      16'sd2, 16'sd5, 16'sd128, 16'sd128, 16'sd515, 16'sd256},
    '{1'b1, 6'd0, 6'd0, 7'd3, 7'd0, 9'd0, 1'b0,
      16'sd0, 16'sd3, -16'sd1, 16'sd0, 16'sd3, 16'sd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive the selected direction from the arguments, the other with decoy values
  task automatic set_cfg(input logic w, input logic [5:0] css, input logic [5:0] sts,
                         input logic [6:0] csp, input logic [6:0] stp,
                         input logic [8:0] cyc, input logic ctl,
                         input logic [1:0] wm, input logic [3:0] fl);
    we = w; wmode = wm; flt = fl;
    if (w) begin
      cs_set_wr = css; st_set_wr = sts; cs_pul_wr = csp; st_pul_wr = stp;
      cyc_wr = cyc; wr_ctl = ctl;
      cs_set_rd = 6'd3; st_set_rd = 6'd3; cs_pul_rd = 7'd1; st_pul_rd = 7'd1;
      cyc_rd = 9'd2; rd_ctl = !ctl;
    end else begin
      cs_set_rd = css; st_set_rd = sts; cs_pul_rd = csp; st_pul_rd = stp;
      cyc_rd = cyc; rd_ctl = ctl;
      cs_set_wr = 6'd3; st_set_wr = 6'd3; cs_pul_wr = 7'd1; st_pul_wr = 7'd1;
      cyc_wr = 9'd2; wr_ctl = !ctl;
    end
  endtask

  task automatic launch();
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1;
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  // runs from access cycle 0 until the done cycle; ends at the done cycle's falling edge
  task automatic measure(input int wfrom, input int wlen,
                         output int cs_s, output int cs_l, output int st_s,
                         output int st_l, output int tot, output int smp,
                         output int other_low);
    logic st_n, ot_n;
    cs_s = -1; cs_l = 0; st_s = -1; st_l = 0; tot = -1; smp = -1; other_low = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      st_n = we ? wr_n : rd_n;
      ot_n = we ? rd_n : wr_n;
      if (!cs_n) begin if (cs_s < 0) cs_s = k; cs_l++; end
      if (!st_n) begin if (st_s < 0) st_s = k; st_l++; end
      if (!ot_n) other_low++;
      if (sample && smp < 0) smp = k;
      wait_n = !(k >= wfrom && k < wfrom + wlen);
      if (done) begin tot = k; break; end
    end
    wait_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cs_s, cs_l, st_s, st_l, tot, smp, ol, gap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 1);
    chk("R1 rd_n", rd_n, 1);
    chk("R1 wr_n", wr_n, 1);
    chk("R1 done", done, 0);
    chk("R1 sample", sample, 0);
    chk("R1 ready", ready, 1);

    // table walk: R3 R4 R5 R6 R8 and stretch R7
    for (int i = 0; i < 4; i++) begin
      set_cfg(VECS[i].we, VECS[i].css, VECS[i].sts, VECS[i].csp, VECS[i].stp,
              VECS[i].cyc, VECS[i].ctl, 2'd0, 4'd0);
      launch();
      measure(0, 0, cs_s, cs_l, st_s, st_l, tot, smp, ol);
      chk($sformatf("R3 v%0d cs start", i), cs_s, VECS[i].e_cs_s);
      chk($sformatf("R4 v%0d cs len", i), cs_l, VECS[i].e_cs_l);
      chk($sformatf("R3 v%0d strobe start", i), st_s, VECS[i].e_st_s);
      chk($sformatf("R4 v%0d strobe len", i), st_l, VECS[i].e_st_l);
      chk($sformatf("R5 v%0d done index", i), tot, VECS[i].e_tot);
      chk($sformatf("R8 v%0d sample index", i), smp, VECS[i].e_smp);
      chk($sformatf("R6 v%0d other strobe low", i), ol, 0);
      chk($sformatf("R7 v%0d strobes at done", i), {cs_n, rd_n, wr_n}, 7);
    end

    // R5 all-zero fields give a one-cycle access
    set_cfg(1'b1, 6'd0, 6'd0, 7'd0, 7'd0, 9'd0, 1'b1, 2'd0, 4'd0);
    launch();
    measure(0, 0, cs_s, cs_l, st_s, st_l, tot, smp, ol);
    chk("R5 zero done index", tot, 1);
    chk("R4 zero pulse strobe len", st_l + cs_l, 0);
    chk("R8 zero pulse no sample", smp, -1);

    // R10 freeze: wait low in cycles 2..4
    set_cfg(1'b1, 6'd0, 6'd1, 7'd4, 7'd2, 9'd6, 1'b1, 2'd2, 4'd0);
    launch();
    measure(2, 3, cs_s, cs_l, st_s, st_l, tot, smp, ol);
    chk("R10 freeze done index", tot, 9);
    chk("R10 freeze strobe len", st_l, 5);
    chk("R10 freeze cs len", cs_l, 7);
    chk("R10 freeze sample index", smp, 6);

    // R11 ready: wait low in cycles 0..4, hold only at pulse end
    set_cfg(1'b1, 6'd0, 6'd1, 7'd5, 7'd2, 9'd6, 1'b1, 2'd3, 4'd0);
    launch();
    measure(0, 5, cs_s, cs_l, st_s, st_l, tot, smp, ol);
    chk("R11 ready done index", tot, 9);
    chk("R11 ready strobe len", st_l, 5);
    chk("R11 ready cs len", cs_l, 8);

    // R9 disabled codes 0 and 1 ignore wait
    for (int m = 0; m < 2; m++) begin
      set_cfg(1'b1, 6'd0, 6'd1, 7'd5, 7'd2, 9'd6, 1'b1, 2'(m), 4'd0);
      launch();
      measure(0, 5, cs_s, cs_l, st_s, st_l, tot, smp, ol);
      chk($sformatf("R9 mode%0d done index", m), tot, 6);
      chk($sformatf("R9 mode%0d strobe len", m), st_l, 2);
    end

    // R12 float gap after a read, request held during the gap
    set_cfg(1'b0, 6'd0, 6'd0, 7'd2, 7'd1, 9'd3, 1'b0, 2'd0, 4'd5);
    launch();
    measure(0, 0, cs_s, cs_l, st_s, st_l, tot, smp, ol);
    chk("R12 ready low at read done", ready, 0);
    set_cfg(1'b1, 6'd0, 6'd0, 7'd1, 7'd1, 9'd2, 1'b0, 2'd0, 4'd7);
    req = 1'b1;
    gap = 0;
    while (cs_n && gap < 50) begin
      @(negedge clk);
      gap++;
    end
    req = 1'b0;
    chk("R12 read-to-next gap", gap, 6);
    // write with float 7: ready must return in its done cycle
    while (!done && gap < 100) begin
      @(negedge clk);
      gap++;
    end
    chk("R12 ready at write done", ready, 1);
    chk("R2 no restart after release", {done, cs_n}, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule